// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface Model

This block is a synthesizable model of a byte-wide flash memory that is controlled entirely through software command sequences. The model samples a chip-enable, output-enable and write-enable bus with a system clock. Multi-write unlock sequences start byte programming, chip erase, a product-identification readout and a permanent write lockout of a low boot region. The storage is a register array whose erased value is all ones. A byte program can only clear bits.

Program and erase are timed by an internal cycle counter whose lengths are parameters. While an operation runs, a read returns a status byte in place of array data. Bit 7 of that byte is the complement of the final bit 7. Bit 6 alternates on each read access. A host can therefore poll for completion with either method.

The full-size device uses `ADDR_W`=16 and `BOOT_AW`=13, which gives 64K bytes with an 8K boot region. The defaults are scaled down to 4K bytes with a 512-byte boot region. In both cases the command addresses 5555h and 2AAAh are truncated to `ADDR_W` bits, which gives 555h and AAAh by default.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset every byte reads FFh, the lockout is off, identification mode is off and no operation is busy.
- R2: The writes AAh@555h, 55h@AAAh, A0h@555h, then D@A start a program of address A. Address A reads the new value `PROG_CYC` cycles after the last write ends.
- R3: A program stores the old byte AND the written byte, so it never sets a 0 bit back to 1.
- R4: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 10h@555h erase the array to FFh after `ERASE_CYC` cycles. Bytes of a locked boot region are left unchanged.
- R5: The same six writes ending in 40h instead of 10h set the boot lockout, which stays set until reset. Once it is set, a program aimed at an address below 2^`BOOT_AW` is dropped and does not go busy, and an erase keeps those bytes. Addresses above the boot region stay writable.
- R6: While busy, a read returns {s7, t, 6'b0}. s7 is the inverse of bit 7 of the byte being programmed, or 0 during an erase. t is 0 on the first read after launch and flips after every read access.
- R7: Writes that end while an operation is busy are ignored and do not advance the decoder.
- R8: A write that does not match the next expected step of a sequence returns the decoder to idle, so the remaining writes of that sequence have no effect.
- R9: The writes AAh@555h, 55h@AAAh, 90h@555h enter identification mode. In that mode, reads of address 0, 1 and 2 return `MFR_ID`, `DEV_ID` and {7'b0, lockout}, and every other address reads 00h.
- R10: Identification mode is left by a single F0h write to any address, or by the unlock pair followed by F0h@555h.
- R11: A write counts only while CE and WE are low and OE is high. The address is taken in the first cycle of that window and the data in its last cycle.
- R12: `data_oe_o` is high exactly while CE and OE are low and WE is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, status or identification byte |
| data_oe_o | output | 1 | Read drive enable |

## Verification
Every write holds the address only in its first active cycle and the data only in its last. A model that samples either at the wrong point would program a scrambled location or value. The status polls check both the inverted bit 7 and the alternation of bit 6, so a model that exposes array data early, or never toggles, shows up. A command sequence is sent during a busy program, and a broken sequence is sent with a wrong data byte or a wrong address; a decoder that accepts either would leave those bytes changed. After lockout, a boot-region program must read back at once with the old value, and a later erase must spare that byte while it clears the rest. A model that still programs the boot region or erases it would fail both checks.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PDATA, SQ_EXT0, SQ_EXT1, SQ_EXT2
  } seq_st_e;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_EXTEND = 8'h80;
  localparam logic [7:0] CMD_ERASE  = 8'h10;
  localparam logic [7:0] CMD_LOCK   = 8'h40;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
endpackage

// File: rtl/flash_bus_cap.sv
module flash_bus_cap #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_en_o,
  output logic          rd_start_o
);
  logic wr_act, wr_q, rd_q;

  assign wr_act     = ~ce_ni & ~we_ni & oe_ni;
  assign rd_en_o    = ~ce_ni & ~oe_ni & we_ni;
  assign wr_stb_o   = wr_q & ~wr_act;
  assign rd_start_o = rd_en_o & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_en_o;
      if (wr_act && !wr_q) wr_addr_o <= addr_i;  // later falling edge
      if (wr_act)          wr_data_o <= data_i;  // last value before release
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);  // R11
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_emu_pkg::*;
#(
  parameter int AW      = 12,
  parameter int BOOT_AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          busy_i,
  output logic          launch_prog_o,
  output logic          launch_erase_o,
  output logic          id_mode_o,
  output logic          lock_o
);
  localparam logic [AW-1:0] ADR_A = AW'(16'h5555);
  localparam logic [AW-1:0] ADR_B = AW'(16'h2AAA);

  seq_st_e st_q, st_d;
  logic    id_d, lock_d, hit_a, hit_b, in_boot, take;

  assign hit_a   = (addr_i == ADR_A);
  assign hit_b   = (addr_i == ADR_B);
  assign in_boot = (addr_i[AW-1:BOOT_AW] == '0);
  assign take    = wr_stb_i & ~busy_i;

  always_comb begin
    st_d           = st_q;
    id_d           = id_mode_o;
    lock_d         = lock_o;
    launch_prog_o  = 1'b0;
    launch_erase_o = 1'b0;
    if (take) begin
      st_d = SQ_IDLE;
      if (st_q == SQ_PDATA) begin
        launch_prog_o = ~(lock_o & in_boot);
      end else if (data_i == CMD_RESET) begin
        id_d = 1'b0;
      end else begin
        unique case (st_q)
          SQ_IDLE: if (hit_a && data_i == CMD_KEY1) st_d = SQ_UNL1;
          SQ_UNL1: if (hit_b && data_i == CMD_KEY2) st_d = SQ_UNL2;
          SQ_UNL2: if (hit_a) begin
            if (data_i == CMD_PROG)   st_d = SQ_PDATA;
            if (data_i == CMD_EXTEND) st_d = SQ_EXT0;
            if (data_i == CMD_IDENT)  id_d = 1'b1;
          end
          SQ_EXT0: if (hit_a && data_i == CMD_KEY1) st_d = SQ_EXT1;
          SQ_EXT1: if (hit_b && data_i == CMD_KEY2) st_d = SQ_EXT2;
          SQ_EXT2: if (hit_a) begin
            if (data_i == CMD_ERASE) launch_erase_o = 1'b1;
            if (data_i == CMD_LOCK)  lock_d = 1'b1;
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      id_mode_o <= 1'b0;
      lock_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      id_mode_o <= id_d;
      lock_o    <= lock_d;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);  // R5
  AST_ID_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && st_q != SQ_PDATA && data_i == CMD_RESET) |=> !id_mode_o);  // R10
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(lock_o));  // R7
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic erase_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= erase_i ? CW'(ERASE_CYC) : CW'(PROG_CYC);
    else if (busy_o)  cnt_q <= cnt_q - CW'(1);
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);  // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);  // R2
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW      = 12,
  parameter int BOOT_AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic          erase_i,
  input  logic          lock_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BOOT  = 1 << BOOT_AW;

  logic [7:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (!(lock_i && i < BOOT)) mem_q[i] <= 8'hFF;
    end else if (prog_i) begin
      mem_q[addr_i] <= mem_q[addr_i] & data_i;
    end
  end

  AST_BOOT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && lock_i) |-> (addr_i[AW-1:BOOT_AW] != '0));  // R5
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_i && erase_i));  // R4
endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu #(
  parameter int         ADDR_W    = 12,
  parameter int         BOOT_AW   = 9,
  parameter int         PROG_CYC  = 24,
  parameter int         ERASE_CYC = 64,
  parameter logic [7:0] MFR_ID    = 8'h5A,
  parameter logic [7:0] DEV_ID    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  logic              wr_stb, rd_start, busy, done;
  logic              l_prog, l_erase, id_mode, lock;
  logic [ADDR_W-1:0] wr_addr, pend_addr;
  logic [7:0]        wr_data, pend_data, arr_rd, id_val, stat;
  logic              pend_erase, tog_q;

  flash_bus_cap #(.AW(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(data_oe_o), .rd_start_o(rd_start)
  );

  flash_cmd_seq #(.AW(ADDR_W), .BOOT_AW(BOOT_AW)) u_seq (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .addr_i(wr_addr), .data_i(wr_data),
    .busy_i(busy), .launch_prog_o(l_prog), .launch_erase_o(l_erase),
    .id_mode_o(id_mode), .lock_o(lock)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(l_prog | l_erase), .erase_i(l_erase),
    .busy_o(busy), .done_o(done)
  );

  flash_array #(.AW(ADDR_W), .BOOT_AW(BOOT_AW)) u_arr (
    .clk_i, .rst_ni, .prog_i(done & ~pend_erase), .erase_i(done & pend_erase),
    .lock_i(lock), .addr_i(pend_addr), .data_i(pend_data),
    .rd_addr_i(addr_i), .rd_data_o(arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_erase <= 1'b0;
      tog_q      <= 1'b0;
    end else if (l_prog || l_erase) begin
      pend_addr  <= wr_addr;
      pend_data  <= wr_data;
      pend_erase <= l_erase;
      tog_q      <= 1'b0;
    end else if (busy && rd_start) begin
      tog_q <= ~tog_q;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(0): id_val = MFR_ID;
      ADDR_W'(1): id_val = DEV_ID;
      ADDR_W'(2): id_val = {7'b0, lock};
      default:    id_val = 8'h00;
    endcase
  end

  assign stat   = {~pend_erase & ~pend_data[7], tog_q, 6'b0};
  assign data_o = busy ? stat : (id_mode ? id_val : arr_rd);

  AST_TOGGLE_ON_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_start && !done) |=> (tog_q != $past(tog_q)));  // R6
endmodule

// File: tb/tb_flash_cmd_emu.sv
`timescale 1ns/100ps
module tb_flash_cmd_emu;
  localparam int AW = 12, PC = 24, EC = 64;
  localparam logic [AW-1:0] A1 = 12'h555, A2 = 12'hAAA;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe;

  flash_cmd_emu #(.ADDR_W(AW), .BOOT_AW(9), .PROG_CYC(PC), .ERASE_CYC(EC),
                  .MFR_ID(8'h5A), .DEV_ID(8'hA5)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe));

  always #2 clk = ~clk;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];
  int checks = 0, fails = 0;
  logic rd_req = 0, fin = 0;

  task automatic chk(input logic ok, input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd_req && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(dout == it.exp, it.req, dout, it.exp);
      chk(doe == 1'b1, "R12", {7'b0, doe}, 8'h01);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl = 1'b1);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = oe_lvl; addr = a; din = ~d;
    @(negedge clk); addr = ~a; din = d;  // R11: address from first cycle, data from last
    #1;
    if (!oe_lvl) chk(doe == 1'b0, "R12", {7'b0, doe}, 8'h00);
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string r);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    sb_q.push_back('{e, r}); rd_req = 1;
    @(negedge clk); ce_n = 1; oe_n = 1; rd_req = 0;
  endtask

  task automatic unlock(); wr(A1, 8'hAA); wr(A2, 8'h55); endtask
  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(A1, 8'hA0); wr(a, d);
  endtask
  task automatic ext(input logic [7:0] last);
    unlock(); wr(A1, 8'h80); unlock(); wr(A1, last);
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(doe == 1'b0, "R12", {7'b0, doe}, 8'h00);
    rd(12'h000, 8'hFF, "R1");
    rd(12'hFFF, 8'hFF, "R1");
    unlock(); wr(A1, 8'h90); rd(12'h002, 8'h00, "R1"); wr(12'h123, 8'hF0);

    // program with polling
    prog(12'h345, 8'h3C);
    rd(12'h345, 8'h80, "R6");
    rd(12'h345, 8'hC0, "R6");
    rd(12'h000, 8'h80, "R6");
    idle(PC + 2);
    rd(12'h345, 8'h3C, "R2");
    rd(12'h346, 8'hFF, "R11");
    prog(12'h345, 8'hF0); idle(PC + 2);
    rd(12'h345, 8'h30, "R3");

    // broken sequences
    wr(A1, 8'hAA); wr(A2, 8'h56); wr(A1, 8'hA0); wr(12'h400, 8'h00);
    rd(12'h400, 8'hFF, "R8");
    unlock(); wr(A2, 8'hA0); wr(12'h401, 8'h00);
    rd(12'h401, 8'hFF, "R8");

    // OE low inhibits writes
    wr(A1, 8'hAA, 1'b0); wr(A2, 8'h55, 1'b0); wr(A1, 8'hA0, 1'b0); wr(12'h123, 8'h00, 1'b0);
    idle(PC + 2);
    rd(12'h123, 8'hFF, "R11");

    // writes during busy
    prog(12'h700, 8'h11);
    prog(12'h701, 8'h00);
    idle(PC + 2);
    rd(12'h701, 8'hFF, "R7");
    rd(12'h700, 8'h11, "R7");

    // identification mode
    unlock(); wr(A1, 8'h90);
    rd(12'h000, 8'h5A, "R9");
    rd(12'h001, 8'hA5, "R9");
    rd(12'h002, 8'h00, "R9");
    rd(12'h345, 8'h00, "R9");
    wr(12'h777, 8'hF0);
    rd(12'h345, 8'h30, "R10");
    unlock(); wr(A1, 8'h90);
    rd(12'h001, 8'hA5, "R9");
    unlock(); wr(A1, 8'hF0);
    rd(12'h700, 8'h11, "R10");

    // erase
    prog(12'h010, 8'h55); idle(PC + 2);
    ext(8'h10);
    rd(12'h010, 8'h00, "R6");
    rd(12'h010, 8'h40, "R6");
    idle(EC + 2);
    rd(12'h010, 8'hFF, "R4");
    rd(12'h345, 8'hFF, "R4");

    // boot lockout
    prog(12'h010, 8'h55); idle(PC + 2);
    ext(8'h40);
    unlock(); wr(A1, 8'h90);
    rd(12'h002, 8'h01, "R5");
    wr(12'h000, 8'hF0);
    prog(12'h010, 8'h00);
    rd(12'h010, 8'h55, "R5");
    prog(12'h1FF, 8'h00);
    rd(12'h1FF, 8'hFF, "R5");
    prog(12'h200, 8'h0F);
    idle(PC + 2);
    rd(12'h200, 8'h0F, "R5");
    ext(8'h10); idle(EC + 2);
    rd(12'h200, 8'hFF, "R4");
    rd(12'h010, 8'h55, "R5");
    unlock(); wr(A1, 8'h90);
    rd(12'h002, 8'h01, "R5");
    wr(12'h000, 8'hF0);

    idle(2);
    if (sb_q.size() != 0) chk(1'b0, "scoreboard", 8'(sb_q.size()), 8'h00);
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule